// File: doc/BRIEF.md
# DDR2 SDRAM Command Decoder

This block sits behind the command pins of a DDR2 memory device that has already been configured. It interprets what the memory controller sends. On every rising clock edge it captures the chip select, the three command strobes, the bank address and the address bus. It classifies the operation and emits a one-cycle command pulse one clock later. The pulse carries the decoded kind, the bank, the row or column address, an autoprecharge flag and a precharge-all flag.

Address bit A10 is read according to the command:
- On an activate it is an ordinary row bit.
- On a read or write it requests autoprecharge.
- On a precharge it selects every bank.

The block also tracks which of the four banks hold an open row. It raises a protocol-error pulse when a read or write targets a closed bank.

Top module: `ddr2_cmd_decode`

## Requirements
- R1: Inputs are captured on the rising clock edge and the decoded result appears on the outputs after that same edge, for exactly one cycle. While `rst_n` is low, every output is 0 and all four banks are closed.
- R2: When `cs_n` is high at an edge, no command is decoded: `cmd_valid` is 0, every pulse field is 0, and `bank_open` keeps its value.
- R3: With `cs_n` low, the active-low strobes {`ras_n`,`cas_n`,`we_n`} decode as follows, and `cmd_valid` is 1 exactly when `cmd_kind` is nonzero:

  | Strobes | Operation | `cmd_kind` |
  |---|---|---|
  | 011 | activate | 1 |
  | 101 | read | 2 |
  | 100 | write | 3 |
  | 010 | precharge | 4 |
  | 001 | refresh | 5 |
  | 000 | mode-register set | 6 |
  | 111 or 110 | no-op | 0, no pulse |

- R4: An activate marks bank `ba` open. It reports `cmd_bank`=`ba` and `cmd_addr` equal to the full address bus, with A10 kept as a row bit.
- R5: A read or write reports `cmd_bank`=`ba` and `cmd_addr` equal to the address bus with bit A10 cleared. It sets `cmd_autopre` to A10. When A10 is 1, the read or write also marks bank `ba` closed.
- R6: A precharge with A10 high closes all four banks regardless of `ba`. It sets `cmd_pre_all`=1, `cmd_bank`=`ba` and `cmd_addr`=0.
- R7: A precharge with A10 low closes only bank `ba` and leaves the other banks as they were. It sets `cmd_pre_all`=0.
- R8: A read or write to a bank that was closed before the command raises `proto_err` for one cycle. The command is still reported with `cmd_valid`=1.
- R9: A refresh pulses with `cmd_bank`=0 and `cmd_addr`=0. A mode-register set pulses with `cmd_bank`=`ba` and `cmd_addr` equal to the address bus. Neither command changes `bank_open`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| ba | input | BANK_W (2) | Bank address |
| addr | input | ADDR_W (13) | Row/column address bus |
| cmd_valid | output | 1 | Decoded command pulse |
| cmd_kind | output | 3 | Command code as in R3 |
| cmd_bank | output | BANK_W (2) | Decoded bank |
| cmd_addr | output | ADDR_W (13) | Row, column or mode value |
| cmd_autopre | output | 1 | Read/write with autoprecharge |
| cmd_pre_all | output | 1 | Precharge of every bank |
| bank_open | output | 4 | Open-row flag per bank |
| proto_err | output | 1 | Read/write to a closed bank |

## Verification
The assertions assume the inputs are valid binary levels at every rising edge. They also assume `rst_n` changes only away from the edge, so each captured command is a single clean strobe pattern. The bench drives all inputs on the falling edge and holds them through the next rising edge.

The random stream includes all eight strobe patterns, chip-select gaps and A10 in both states. This reaches every command and bank combination, including accesses to closed banks, under the same conditions the assertions assume.

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_autopre,
  output logic              cmd_pre_all,
  output logic [(1<<BANK_W)-1:0] bank_open,
  output logic              proto_err
);
  localparam int NBANK = 1 << BANK_W;
  localparam logic [2:0] K_NONE = 3'd0, K_ACT = 3'd1, K_RD = 3'd2, K_WR = 3'd3,
                         K_PRE = 3'd4, K_REF = 3'd5, K_MRS = 3'd6;
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  logic [2:0]        kind_d;
  logic              a10, rdwr;
  logic [NBANK-1:0]  open_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BANK_W-1:0] bank_d;

  assign a10  = addr[AP_BIT];
  assign rdwr = (kind_d == K_RD) || (kind_d == K_WR);

  always_comb begin
    kind_d = K_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  kind_d = K_ACT;
        3'b101:  kind_d = K_RD;
        3'b100:  kind_d = K_WR;
        3'b010:  kind_d = K_PRE;
        3'b001:  kind_d = K_REF;
        3'b000:  kind_d = K_MRS;
        default: kind_d = K_NONE;
      endcase
    end
  end

  always_comb begin
    open_d = bank_open;
    case (kind_d)
      K_ACT:      open_d[ba] = 1'b1;
      K_RD, K_WR: if (a10) open_d[ba] = 1'b0;
      K_PRE:      if (a10) open_d = '0; else open_d[ba] = 1'b0;
      default:    ;
    endcase
  end

  always_comb begin
    case (kind_d)
      K_ACT, K_MRS: addr_d = addr;
      K_RD, K_WR:   addr_d = addr & ~AP_MASK;
      default:      addr_d = '0;
    endcase
  end

  assign bank_d = (kind_d == K_NONE || kind_d == K_REF) ? '0 : ba;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_kind    <= K_NONE;
      cmd_bank    <= '0;
      cmd_addr    <= '0;
      cmd_autopre <= 1'b0;
      cmd_pre_all <= 1'b0;
      bank_open   <= '0;
      proto_err   <= 1'b0;
    end else begin
      cmd_valid   <= kind_d != K_NONE;
      cmd_kind    <= kind_d;
      cmd_bank    <= bank_d;
      cmd_addr    <= addr_d;
      cmd_autopre <= rdwr && a10;
      cmd_pre_all <= (kind_d == K_PRE) && a10;
      bank_open   <= open_d;
      proto_err   <= rdwr && !bank_open[ba];
    end
  end
endmodule

// File: rtl/ddr2_cmd_decode_chk.sv
module ddr2_cmd_decode_chk #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ADDR_W-1:0] addr,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_autopre,
  input logic              cmd_pre_all,
  input logic [(1<<BANK_W)-1:0] bank_open,
  input logic              proto_err
);
  logic [2:0] strb;
  assign strb = {ras_n, cas_n, we_n};

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!cmd_valid && $stable(bank_open)));

  assert_kind_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid == (cmd_kind != 3'd0));

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strb == 3'b011) |=> (bank_open[$past(ba)] && cmd_addr == $past(addr)));

  assert_autopre_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_autopre |-> (cmd_kind == 3'd2 || cmd_kind == 3'd3));

  assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strb == 3'b010 && addr[AP_BIT]) |=> (bank_open == '0 && cmd_pre_all));

  assert_pre_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strb == 3'b010 && !addr[AP_BIT]) |=> !bank_open[$past(ba)]);

  assert_err_decoded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (cmd_valid && (cmd_kind == 3'd2 || cmd_kind == 3'd3)));

  assert_ref_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && strb == 3'b001) |=> ($stable(bank_open) && cmd_kind == 3'd5));
endmodule

bind ddr2_cmd_decode ddr2_cmd_decode_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)) u_chk (.*);

// File: tb/test_ddr2_cmd_decode.sv
`timescale 1ns/1ps
module test_ddr2_cmd_decode;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic cmd_valid, cmd_autopre, cmd_pre_all, proto_err;
  logic [2:0] cmd_kind;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_addr;
  logic [3:0] bank_open;

  int checks = 0, fails = 0;
  bit done = 0;
  bit [3:0] m_open = '0;

  always #2 clk = ~clk;

  ddr2_cmd_decode i_ddr2_cmd_decode (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic cmd(bit c, bit [2:0] s, bit [1:0] b, bit [12:0] a);
    int kind, ebank, eaddr, req_i;
    bit ap, pa, err;
    string req;
    bit [3:0] nopen;
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = s; ba = b; addr = a;
    kind = 0; ap = 0; pa = 0; err = 0; ebank = 0; eaddr = 0; nopen = m_open;
    if (!c) begin
      case (s)
        3'b011: kind = 1;
        3'b101: kind = 2;
        3'b100: kind = 3;
        3'b010: kind = 4;
        3'b001: kind = 5;
        3'b000: kind = 6;
        default: kind = 0;
      endcase
    end
    req = "R9";
    case (kind)
      1: begin req = "R4"; ebank = b; eaddr = a; nopen[b] = 1; end
      2, 3: begin
        req = "R5"; ebank = b; eaddr = a & 13'h1BFF; ap = a[10];
        err = !m_open[b];
        if (ap) nopen[b] = 0;
      end
      4: begin
        ebank = b; pa = a[10];
        if (pa) begin req = "R6"; nopen = 0; end
        else begin req = "R7"; nopen[b] = 0; end
      end
      6: begin ebank = b; eaddr = a; end
      default: ;
    endcase
    if (c) req = "R2";
    @(posedge clk); #1;
    chk(req, "cmd_valid", cmd_valid, kind != 0);
    chk("R3", "cmd_kind", cmd_kind, kind);
    chk(req, "cmd_bank", cmd_bank, ebank);
    chk(req, "cmd_addr", cmd_addr, eaddr);
    chk(req, "cmd_autopre", cmd_autopre, ap);
    chk(req, "cmd_pre_all", cmd_pre_all, pa);
    chk(req, "bank_open", bank_open, nopen);
    chk("R8", "proto_err", proto_err, err);
    m_open = nopen;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    #11;
    chk("R1", "reset cmd_valid", cmd_valid, 0);
    chk("R1", "reset bank_open", bank_open, 0);
    chk("R1", "reset proto_err", proto_err, 0);
    @(negedge clk); rst_n = 1'b1;
    // R8 read of closed bank, then R4 opens, R5 reads with and without autoprecharge
    cmd(0, 3'b101, 2'd1, 13'h0010);
    cmd(0, 3'b011, 2'd1, 13'h1555);
    cmd(0, 3'b011, 2'd2, 13'h0400);
    cmd(0, 3'b101, 2'd1, 13'h0020);
    cmd(0, 3'b100, 2'd1, 13'h0430);
    cmd(0, 3'b100, 2'd1, 13'h0008);
    // R2 deselect with strobes that would otherwise activate
    cmd(1, 3'b011, 2'd3, 13'h1FFF);
    // R7 single precharge, R6 precharge all
    cmd(0, 3'b011, 2'd0, 13'h0001);
    cmd(0, 3'b011, 2'd3, 13'h0002);
    cmd(0, 3'b010, 2'd0, 13'h0000);
    cmd(0, 3'b010, 2'd1, 13'h0400);
    // R9 refresh, mode set, no-ops
    cmd(0, 3'b011, 2'd2, 13'h0003);
    cmd(0, 3'b001, 2'd2, 13'h0777);
    cmd(0, 3'b000, 2'd3, 13'h0432);
    cmd(0, 3'b111, 2'd1, 13'h0FFF);
    cmd(0, 3'b110, 2'd1, 13'h0FFF);
    // cross-check every kind with random traffic against the model
    for (int i = 0; i < 3000; i++)
      cmd(($urandom % 6) == 0, 3'($urandom), 2'($urandom), 13'($urandom));
    finish_up();
  end
endmodule